// File: doc/BRIEF.md
# Snapshot-Buffered Timekeeping Register Bank

This block holds a running calendar clock of eight BCD bytes and places a shadow buffer between those counters and a serial register port. A one-second tick advances the counters at all times. The serial engine in front of the block decodes the bus and hands over events: a transaction start, a snapshot pulse for a read or for a write (raised on the acknowledge edge just before the first data byte), byte write strobes with an address, a stop, an abort, and a level that says register writes are permitted.

On a read snapshot the live time is frozen into the buffer, so every byte that a sequential read returns belongs to the same instant while the counters go on ticking. On a write snapshot the buffer is loaded with the current time, incoming bytes patch only the bytes they address, and a valid stop with writes permitted copies the whole buffer into the counters in one step. An abort, a new start, or a stop without permission throws the patched copy away, and the live time is left as it was. The live counter bytes are also brought out in full so that alarm comparison logic elsewhere always sees the true current time, whatever the port is doing.

Top module: `rtc_shadow_bank`

## Requirements
- R1: After reset the live time is 2000-01-01 00:00:00 with weekday 6 (live_time = 64'h2006_0001_0100_0000), and every buffer byte reads 8'h00.
- R2: Byte address k holds live_time[8k+7:8k]; addresses are 0 seconds, 1 minutes, 2 hours (00-23), 3 day of month, 4 month (01-12), 5 year within century (00-99), 6 weekday (0-6), 7 century (00-99), all in packed BCD.
- R3: Each cycle with sec_tick high (and no commit) advances the time by one second, carrying seconds 59 to minutes, minutes 59 to hours, hour 23 to the day (the weekday advances with it, 6 wrapping to 0), month 12 to the year, and year 99 to the century.
- R4: The day carries into the month after 28 or 29 in month 2, after 30 in months 4, 6, 9 and 11, and after 31 in the others; the year is a leap year when the full year (century*100 + year) is divisible by 4, except a century year whose century is not divisible by 4.
- R5: A snap_rd pulse copies all eight live bytes into the buffer at that clock edge; until the read ends the buffer does not change, and rd_data always shows the buffer byte at rd_addr.
- R6: A snap_wr pulse copies the live time into the buffer; a byte_we strobe while a write is open replaces only the byte at byte_addr, and a byte_we strobe at any other time leaves the buffer unchanged.
- R7: A txn_stop while a write is open, with wr_allow high and at least one byte written, loads the buffer into the counters at that edge; a sec_tick in the same cycle is dropped. A stop with no byte written loads nothing.
- R8: txn_abort or txn_start clears the buffer to zero and ends the transaction without touching the counters; a txn_stop with wr_allow low ends a write without a load.
- R9: After a load the counters hold the loaded value until the next sec_tick, which advances them from that value.
- R10: Snapshots, byte writes and reads never stall the counters: ticks during an open read or write advance live_time as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| txn_start | input | 1 | A new bus transaction begins |
| snap_rd | input | 1 | Acknowledge edge before the first read byte |
| snap_wr | input | 1 | Acknowledge edge before the first write byte |
| byte_we | input | 1 | Incoming data byte strobe |
| byte_addr | input | 3 | Register address of the incoming byte |
| byte_data | input | 8 | Incoming data byte |
| txn_stop | input | 1 | Stop condition ends the transaction |
| txn_abort | input | 1 | Transaction ended invalidly |
| wr_allow | input | 1 | Register writes permitted (sampled at stop) |
| rd_addr | input | 3 | Register address for read data |
| rd_data | output | 8 | Buffer byte at rd_addr |
| live_time | output | 64 | The eight live counter bytes, byte k at bits 8k+7:8k |

## Verification
The hardest situations to reach are those where the counters and the buffer disagree: a tick arriving while a write is open, so that a later commit must move the time backwards to the snapshot, and a tick landing in the very cycle of the committing stop. The bench reaches both by pulsing sec_tick between snap_wr and txn_stop and by raising sec_tick together with txn_stop, then compares live_time with a reference calendar kept in the bench. The calendar corners (month ends, leap and non-leap century years, century rollover) are reached by loading chosen times through full eight-byte writes and giving a single tick.

// File: rtl/rtc_bank_pkg.sv
package rtc_bank_pkg;

    localparam int unsigned RB_BYTES = 8;
    localparam int unsigned RB_W     = 8;
    localparam int unsigned RB_AW    = $clog2(RB_BYTES);

    localparam int unsigned IDX_SEC = 0;
    localparam int unsigned IDX_MIN = 1;
    localparam int unsigned IDX_HR  = 2;
    localparam int unsigned IDX_DAY = 3;
    localparam int unsigned IDX_MON = 4;
    localparam int unsigned IDX_YR  = 5;
    localparam int unsigned IDX_DOW = 6;
    localparam int unsigned IDX_CEN = 7;

    typedef logic [RB_W-1:0]                rb_byte_t;
    typedef logic [RB_BYTES-1:0][RB_W-1:0]  rb_time_t;
    typedef logic [RB_AW-1:0]               rb_addr_t;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_RD   = 2'd1,
        SH_WR   = 2'd2
    } sh_state_e;

    // 2000-01-01 00:00:00, weekday 6
    localparam rb_time_t RB_RESET_TIME = {8'h20, 8'h06, 8'h00, 8'h01,
                                          8'h01, 8'h00, 8'h00, 8'h00};

    // Packed BCD to binary (0..165 for any byte)
    function automatic logic [7:0] bcd_to_bin(input rb_byte_t b);
        return (8'(b[7:4]) * 8'd10) + 8'(b[3:0]);
    endfunction

    // One BCD increment with decimal carry between nibbles
    function automatic rb_byte_t bcd_step(input rb_byte_t b);
        rb_byte_t r;
        if (b[3:0] == 4'd9) begin
            r = {b[7:4] + 4'd1, 4'd0};
        end else begin
            r = {b[7:4], b[3:0] + 4'd1};
        end
        return r;
    endfunction

    // Leap rule from BCD century and year
    function automatic logic is_leap(input rb_byte_t cen, input rb_byte_t yr);
        logic [7:0] yb;
        logic [7:0] cb;
        yb = bcd_to_bin(yr);
        cb = bcd_to_bin(cen);
        return (yb != 8'd0) ? (yb[1:0] == 2'd0) : (cb[1:0] == 2'd0);
    endfunction

    // Length of a month given its binary number
    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap);
        logic [7:0] r;
        case (mon)
            8'd2:                      r = leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   r = 8'd30;
            default:                   r = 8'd31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
    import rtc_bank_pkg::*;
(
    input  rb_time_t cur,
    output rb_time_t nxt
);

    localparam logic [7:0] SEC_LAST = 8'd59;
    localparam logic [7:0] MIN_LAST = 8'd59;
    localparam logic [7:0] HR_LAST  = 8'd23;
    localparam logic [7:0] DOW_LAST = 8'd6;
    localparam logic [7:0] MON_LAST = 8'd12;
    localparam logic [7:0] YR_LAST  = 8'd99;
    localparam logic [7:0] CEN_LAST = 8'd99;

    logic       c_min;
    logic       c_hr;
    logic       c_day;
    logic       c_mon;
    logic       c_yr;
    logic       c_cen;
    logic [7:0] dim;

    always_comb begin
        nxt   = cur;
        dim   = month_days(bcd_to_bin(cur[IDX_MON]), is_leap(cur[IDX_CEN], cur[IDX_YR]));

        // carry chain, each stage wraps on reaching (or passing) its last value
        c_min = bcd_to_bin(cur[IDX_SEC]) >= SEC_LAST;
        c_hr  = c_min && (bcd_to_bin(cur[IDX_MIN]) >= MIN_LAST);
        c_day = c_hr  && (bcd_to_bin(cur[IDX_HR])  >= HR_LAST);
        c_mon = c_day && (bcd_to_bin(cur[IDX_DAY]) >= dim);
        c_yr  = c_mon && (bcd_to_bin(cur[IDX_MON]) >= MON_LAST);
        c_cen = c_yr  && (bcd_to_bin(cur[IDX_YR])  >= YR_LAST);

        nxt[IDX_SEC] = c_min ? '0 : bcd_step(cur[IDX_SEC]);
        if (c_min) begin
            nxt[IDX_MIN] = c_hr ? '0 : bcd_step(cur[IDX_MIN]);
        end
        if (c_hr) begin
            nxt[IDX_HR] = c_day ? '0 : bcd_step(cur[IDX_HR]);
        end
        if (c_day) begin
            nxt[IDX_DAY] = c_mon ? 8'h01 : bcd_step(cur[IDX_DAY]);
            nxt[IDX_DOW] = (bcd_to_bin(cur[IDX_DOW]) >= DOW_LAST) ? '0 : bcd_step(cur[IDX_DOW]);
        end
        if (c_mon) begin
            nxt[IDX_MON] = c_yr ? 8'h01 : bcd_step(cur[IDX_MON]);
        end
        if (c_yr) begin
            nxt[IDX_YR] = c_cen ? '0 : bcd_step(cur[IDX_YR]);
        end
        if (c_cen) begin
            nxt[IDX_CEN] = (bcd_to_bin(cur[IDX_CEN]) >= CEN_LAST) ? '0 : bcd_step(cur[IDX_CEN]);
        end
    end

endmodule

// File: rtl/rtc_live_counters.sv
module rtc_live_counters
    import rtc_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     load,
    input  rb_time_t load_val,
    output rb_time_t live
);

    typedef struct packed {
        rb_time_t t;
    } cnt_state_t;

    cnt_state_t st_d;
    cnt_state_t st_q;
    rb_time_t   adv;

    rtc_calendar_next u_next (
        .cur (st_q.t),
        .nxt (adv)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            // a committed value wins over a coincident tick
            st_d.t = load_val;
        end else if (tick) begin
            st_d.t = adv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.t <= RB_RESET_TIME;
        end else begin
            st_q <= st_d;
        end
    end

    assign live = st_q.t;

endmodule

// File: rtl/rtc_shadow_ctrl.sv
module rtc_shadow_ctrl
    import rtc_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     txn_start,
    input  logic     snap_rd,
    input  logic     snap_wr,
    input  logic     byte_we,
    input  rb_addr_t byte_addr,
    input  rb_byte_t byte_data,
    input  logic     txn_stop,
    input  logic     txn_abort,
    input  logic     wr_allow,
    input  rb_time_t live,
    output rb_time_t shadow,
    output logic     commit,
    output logic     reading
);

    typedef struct packed {
        sh_state_e mode;
        rb_time_t  buf_t;
        logic      wrote;
    } sh_reg_t;

    sh_reg_t sh_d;
    sh_reg_t sh_q;
    logic    discard;

    assign discard = txn_abort | txn_start;

    always_comb begin
        sh_d   = sh_q;
        commit = 1'b0;
        if (discard) begin
            sh_d.mode  = SH_IDLE;
            sh_d.buf_t = '0;
            sh_d.wrote = 1'b0;
        end else if (snap_wr) begin
            sh_d.mode  = SH_WR;
            sh_d.buf_t = live;
            sh_d.wrote = 1'b0;
        end else if (snap_rd) begin
            sh_d.mode  = SH_RD;
            sh_d.buf_t = live;
            sh_d.wrote = 1'b0;
        end else if (txn_stop) begin
            if (sh_q.mode == SH_WR) begin
                if (wr_allow && sh_q.wrote) begin
                    commit = 1'b1;
                end else begin
                    sh_d.buf_t = '0;
                end
            end
            sh_d.mode  = SH_IDLE;
            sh_d.wrote = 1'b0;
        end else if (byte_we && (sh_q.mode == SH_WR)) begin
            sh_d.buf_t[byte_addr] = byte_data;
            sh_d.wrote            = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.mode  <= SH_IDLE;
            sh_q.buf_t <= '0;
            sh_q.wrote <= 1'b0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign shadow  = sh_q.buf_t;
    assign reading = (sh_q.mode == SH_RD);

endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank
    import rtc_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_tick,
    input  logic        txn_start,
    input  logic        snap_rd,
    input  logic        snap_wr,
    input  logic        byte_we,
    input  logic [2:0]  byte_addr,
    input  logic [7:0]  byte_data,
    input  logic        txn_stop,
    input  logic        txn_abort,
    input  logic        wr_allow,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic [63:0] live_time
);

    rb_time_t live_w;
    rb_time_t shadow_w;
    logic     commit_w;
    logic     reading_w;

    rtc_shadow_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .txn_start (txn_start),
        .snap_rd   (snap_rd),
        .snap_wr   (snap_wr),
        .byte_we   (byte_we),
        .byte_addr (byte_addr),
        .byte_data (byte_data),
        .txn_stop  (txn_stop),
        .txn_abort (txn_abort),
        .wr_allow  (wr_allow),
        .live      (live_w),
        .shadow    (shadow_w),
        .commit    (commit_w),
        .reading   (reading_w)
    );

    rtc_live_counters u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .load     (commit_w),
        .load_val (shadow_w),
        .live     (live_w)
    );

    assign rd_data   = shadow_w[rd_addr];
    assign live_time = live_w;

endmodule

// File: rtl/rtc_shadow_bank_chk.sv
module rtc_shadow_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sec_tick,
    input logic        txn_start,
    input logic        snap_rd,
    input logic        snap_wr,
    input logic        txn_stop,
    input logic        txn_abort,
    input logic [63:0] live_time,
    input logic [63:0] shadow,
    input logic        commit,
    input logic        reading
);

    // R9/R3: without a tick or a commit the counters hold
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !commit) |=> $stable(live_time));

    // R7: a commit lands the buffer in the counters
    a_r7_commit_load: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (live_time == $past(shadow)));

    // R5/R6: a snapshot pulse captures the live time
    a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        ((snap_rd || snap_wr) && !txn_abort && !txn_start) |=> (shadow == $past(live_time)));

    // R5: an open read keeps the buffer frozen
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && !snap_rd && !snap_wr && !txn_abort && !txn_start && !txn_stop)
        |=> $stable(shadow));

    // R8: abort clears the buffer and never loads the counters
    a_r8_abort_clear: assert property (@(posedge clk) disable iff (!rst_n)
        txn_abort |=> (shadow == 64'd0));

    a_r8_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_abort || txn_start) |-> !commit);

    // R3/R10: a tick steps the seconds units digit
    a_r3_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !commit && (live_time[3:0] != 4'h9) && (live_time[7:0] < 8'h59))
        |=> (live_time[3:0] == 4'($past(live_time[3:0]) + 4'd1)));

endmodule

bind rtc_shadow_bank rtc_shadow_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .txn_start (txn_start),
    .snap_rd   (snap_rd),
    .snap_wr   (snap_wr),
    .txn_stop  (txn_stop),
    .txn_abort (txn_abort),
    .live_time (live_time),
    .shadow    (shadow_w),
    .commit    (commit_w),
    .reading   (reading_w)
);

// File: tb/rtc_shadow_bank_bench.sv
`timescale 1ns/1ps
module rtc_shadow_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        txn_start = 1'b0;
    logic        snap_rd = 1'b0;
    logic        snap_wr = 1'b0;
    logic        byte_we = 1'b0;
    logic [2:0]  byte_addr = '0;
    logic [7:0]  byte_data = '0;
    logic        txn_stop = 1'b0;
    logic        txn_abort = 1'b0;
    logic        wr_allow = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [63:0] live_time;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] m_live [8];
    logic [7:0] m_shad [8];

    always #2 clk = ~clk;

    rtc_shadow_bank u_rtc_shadow_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .txn_start (txn_start),
        .snap_rd   (snap_rd),
        .snap_wr   (snap_wr),
        .byte_we   (byte_we),
        .byte_addr (byte_addr),
        .byte_data (byte_data),
        .txn_stop  (txn_stop),
        .txn_abort (txn_abort),
        .wr_allow  (wr_allow),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .live_time (live_time)
    );

    // ---------------- reference calendar ----------------
    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int days_in(input int mo, input int full);
        bit leap;
        leap = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
        if (mo == 2) return leap ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic void model_tick();
        int s, mi, h, d, mo, y, w, c;
        s = b2i(m_live[0]); mi = b2i(m_live[1]); h = b2i(m_live[2]); d = b2i(m_live[3]);
        mo = b2i(m_live[4]); y = b2i(m_live[5]); w = b2i(m_live[6]); c = b2i(m_live[7]);
        s++;
        if (s > 59) begin
            s = 0; mi++;
            if (mi > 59) begin
                mi = 0; h++;
                if (h > 23) begin
                    h = 0; w = (w + 1) % 7; d++;
                    if (d > days_in(mo, c * 100 + y)) begin
                        d = 1; mo++;
                        if (mo > 12) begin
                            mo = 1; y++;
                            if (y > 99) begin
                                y = 0; c = (c + 1) % 100;
                            end
                        end
                    end
                end
            end
        end
        m_live[0] = i2b(s); m_live[1] = i2b(mi); m_live[2] = i2b(h); m_live[3] = i2b(d);
        m_live[4] = i2b(mo); m_live[5] = i2b(y); m_live[6] = i2b(w); m_live[7] = i2b(c);
    endfunction

    function automatic logic [63:0] pack_live();
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = m_live[i];
        return r;
    endfunction

    // ---------------- check helpers ----------------
    task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_live(input string tag);
        chk64(tag, live_time, pack_live());
    endtask

    task automatic chk_rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
        rd_addr = a;
        #0.5;
        chk8(tag, rd_data, exp);
    endtask

    // inputs change 1 ns after the rising edge; pulses last one cycle
    task automatic cycle();
        @(posedge clk);
        #1;
        sec_tick = 0; txn_start = 0; snap_rd = 0; snap_wr = 0; byte_we = 0;
        txn_stop = 0; txn_abort = 0; wr_allow = 0;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            sec_tick = 1;
            cycle();
            model_tick();
        end
    endtask

    task automatic put_byte(input logic [2:0] a, input logic [7:0] v);
        byte_we = 1; byte_addr = a; byte_data = v;
        cycle();
    endtask

    task automatic wr_full(input logic [7:0] v [8]);
        snap_wr = 1;
        cycle();
        for (int i = 0; i < 8; i++) m_shad[i] = m_live[i];
        for (int i = 0; i < 8; i++) begin
            put_byte(3'(i), v[i]);
            m_shad[i] = v[i];
        end
        txn_stop = 1; wr_allow = 1;
        cycle();
        for (int i = 0; i < 8; i++) m_live[i] = m_shad[i];
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk64("R1 reset live time", live_time, 64'h2006_0001_0100_0000);
        for (int i = 0; i < 8; i++) chk_rd("R1 reset buffer byte", 3'(i), 8'h00);
    endtask

    task automatic t_count();
        tick_n(70);
        chk_live("R3 seventy ticks");
        chk8("R2 seconds byte at address 0", live_time[7:0], 8'h10);
        chk8("R2 minutes byte at address 1", live_time[15:8], 8'h01);
    endtask

    task automatic t_calendar();
        wr_full('{8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h05, 8'h19});
        chk_live("R7 full write load");
        tick_n(1);
        chk_live("R3 century rollover");
        chk64("R3 explicit new century", live_time, 64'h2006_0001_0100_0000);

        wr_full('{8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h03, 8'h20});
        tick_n(1);
        chk8("R4 leap year gives day 29", live_time[31:24], 8'h29);
        chk_live("R4 leap year full");

        tick_n(86400);
        chk8("R4 after Feb 29 comes March", live_time[39:32], 8'h03);
        chk_live("R4 leap month end");

        wr_full('{8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h00, 8'h01, 8'h21});
        tick_n(1);
        chk8("R4 century year not leap", live_time[31:24], 8'h01);
        chk_live("R4 non-leap century full");

        wr_full('{8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h00, 8'h01, 8'h20});
        tick_n(1);
        chk8("R4 year 2000 is leap", live_time[31:24], 8'h29);

        wr_full('{8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h31, 8'h06, 8'h20});
        tick_n(1);
        chk_live("R4 thirty-day month");
        chk8("R3 weekday wraps 6 to 0", live_time[55:48], 8'h00);
    endtask

    task automatic t_read_snapshot();
        snap_rd = 1;
        cycle();
        for (int i = 0; i < 8; i++) m_shad[i] = m_live[i];
        tick_n(3);
        chk_live("R10 ticks during read");
        for (int i = 0; i < 8; i++) chk_rd("R5 read returns snapshot", 3'(i), m_shad[i]);
        put_byte(3'd0, 8'h33);
        chk_rd("R6 byte strobe ignored during read", 3'd0, m_shad[0]);
        txn_stop = 1;
        cycle();
        chk_live("R5 read stop leaves counters");
    endtask

    task automatic t_partial_write();
        snap_wr = 1;
        cycle();
        for (int i = 0; i < 8; i++) m_shad[i] = m_live[i];
        tick_n(2);
        chk_live("R10 ticks during write");
        put_byte(3'd1, 8'h42);
        m_shad[1] = 8'h42;
        chk_rd("R6 addressed byte patched", 3'd1, 8'h42);
        chk_rd("R6 neighbour byte untouched", 3'd0, m_shad[0]);
        txn_stop = 1; wr_allow = 1;
        cycle();
        for (int i = 0; i < 8; i++) m_live[i] = m_shad[i];
        chk_live("R7 single-byte commit restores snapshot bytes");
        cycle();
        chk_live("R9 loaded value held without tick");
        tick_n(1);
        chk_live("R9 first tick after load");
    endtask

    task automatic t_discard();
        snap_wr = 1;
        cycle();
        put_byte(3'd2, 8'h11);
        txn_abort = 1;
        cycle();
        chk_live("R8 abort leaves counters");
        for (int i = 0; i < 8; i++) chk_rd("R8 abort clears buffer", 3'(i), 8'h00);

        snap_wr = 1;
        cycle();
        put_byte(3'd2, 8'h11);
        txn_stop = 1; wr_allow = 0;
        cycle();
        chk_live("R8 stop without write permission");

        snap_wr = 1;
        cycle();
        put_byte(3'd3, 8'h15);
        tick_n(1);
        txn_start = 1;
        cycle();
        chk_live("R8 new start discards open write");
        chk_rd("R8 start clears buffer", 3'd3, 8'h00);

        snap_wr = 1;
        cycle();
        tick_n(1);
        txn_stop = 1; wr_allow = 1;
        cycle();
        chk_live("R7 stop with no byte written loads nothing");
    endtask

    task automatic t_tick_at_commit();
        snap_wr = 1;
        cycle();
        for (int i = 0; i < 8; i++) m_shad[i] = m_live[i];
        put_byte(3'd0, 8'h30);
        m_shad[0] = 8'h30;
        txn_stop = 1; wr_allow = 1; sec_tick = 1;
        cycle();
        for (int i = 0; i < 8; i++) m_live[i] = m_shad[i];
        chk_live("R7 tick in commit cycle dropped");
        chk8("R7 seconds equal written value", live_time[7:0], 8'h30);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_live[i] = 8'h00;
        m_live[3] = 8'h01; m_live[4] = 8'h01; m_live[6] = 8'h06; m_live[7] = 8'h20;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        cycle();
        t_reset();
        t_count();
        t_calendar();
        t_read_snapshot();
        t_partial_write();
        t_discard();
        t_tick_at_commit();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 195000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule